// File: doc/BRIEF.md
# Cartridge Bus Access Detector

This block watches the asynchronous control lines of a console cartridge bus from inside the FPGA clock domain. Each control line passes through its own shift-register synchronizer. The block tracks when a read or write cycle starts and ends, and it produces clean single-clock strobes for the rest of the cartridge logic. During a read it also drives a data output-enable. That enable opens only after a programmable delay, once returned data is valid, so the data lines do not toggle needlessly.

Two points matter most. The first is that the synchronizers reset to the idle level of each line: high for the active-low strobes and low for the CPU clock. Logic that has just been loaded therefore never sees a cycle that did not happen. The second is that a read ends on the synchronized deassertion of the read strobe, not on a CPU clock edge. During DMA the read strobe can outlast a short CPU clock phase by a wide margin, and ending on the strobe handles that case.

Top module: `bus_access_detect`

## Requirements
- R1: After reset, with every input held at its idle level (strobes and peripheral select high, CPU clock low), `access_o`, `oe_o`, `rd_pulse_o`, `wr_pulse_o` and `cycle_end_o` stay 0 on every clock. In particular, no write to peripheral address 0x00 is reported.
- R2: `cpu_clk_sync_o` is 0 out of reset and follows `cpu_clk_i`. A level change becomes visible on the third rising FPGA clock edge after the input changes.
- R3: When `rd_n_i` falls, `rd_pulse_o` is high for exactly one clock, starting at the third rising edge after the change. `access_o` rises at that same edge.
- R4: `oe_o` is low while `rd_pulse_o` is high. It rises exactly `OE_DELAY` clocks after the edge that raised `rd_pulse_o`, and it stays high while the read strobe remains low.
- R5: When `rd_n_i` rises, `cycle_end_o` pulses for one clock at the third rising edge after the change. `access_o` and `oe_o` both drop at that same edge, and not before it.
- R6: Falling edges of `cpu_clk_i` during a long read, as seen in DMA, neither end the cycle nor close `oe_o`.
- R7: When `wr_n_i` rises, `wr_pulse_o` and `cycle_end_o` pulse together for one clock at the third rising edge after the change. At that edge `wr_addr_o` and `wr_data_o` capture `addr_i` and `data_i`, and `wr_periph_o` captures 1 if the synchronized `periph_n_i` is low (0 otherwise).
- R8: A write cycle never raises `oe_o`. While `wr_n_i` is low, `access_o` is high from the third rising edge after the fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FPGA clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk_i | input | 1 | Console CPU clock, asynchronous |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe |
| periph_n_i | input | 1 | Active-low peripheral-space select |
| addr_i | input | ADDR_W | Peripheral address byte |
| data_i | input | DATA_W | Write data from the bus |
| cpu_clk_sync_o | output | 1 | Synchronized CPU clock level |
| access_o | output | 1 | A read or write cycle is in progress |
| rd_pulse_o | output | 1 | One-clock pulse at read start |
| wr_pulse_o | output | 1 | One-clock pulse at write end |
| cycle_end_o | output | 1 | One-clock pulse at the end of any cycle |
| oe_o | output | 1 | Narrowed data output-enable for reads |
| wr_addr_o | output | ADDR_W | Address captured at write end |
| wr_data_o | output | DATA_W | Data captured at write end |
| wr_periph_o | output | 1 | The captured write targeted peripheral space |

## Verification
The bench builds the block with `OE_DELAY` set to 3 instead of the default 2, and keeps the default synchronizer length of 3. The open delay is therefore different from the synchronizer latency. A mistake that uses one count where the other belongs then moves `oe_o` to a cycle the bench can tell apart. The long DMA-style read keeps the strobe low for more than twenty clocks while the CPU clock toggles, which makes any cycle end tied to the CPU clock visible.

// File: rtl/bus_access_detect.sv
module bus_access_detect #(
  parameter int OE_DELAY = 2,
  parameter int SYNC_LEN = 3,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_clk_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic              periph_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              cpu_clk_sync_o,
  output logic              access_o,
  output logic              rd_pulse_o,
  output logic              wr_pulse_o,
  output logic              cycle_end_o,
  output logic              oe_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_periph_o
);

  localparam int OLD = SYNC_LEN - 1;
  localparam int PRV = SYNC_LEN - 2;
  localparam int DW  = $clog2(OE_DELAY + 1) + 1;

  logic [SYNC_LEN-1:0] rd_sr, wr_sr, pa_sr, ck_sr;
  logic                rd_busy, wr_busy;
  logic [DW-1:0]       dly;

  wire rd_fall = rd_sr[OLD] & ~rd_sr[PRV];
  wire rd_rise = ~rd_sr[OLD] & rd_sr[PRV];
  wire wr_fall = wr_sr[OLD] & ~wr_sr[PRV];
  wire wr_rise = ~wr_sr[OLD] & wr_sr[PRV];

  assign cpu_clk_sync_o = ck_sr[OLD];
  assign access_o       = rd_busy | wr_busy;

  // strobe synchronizers start at the idle level of each line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sr <= '1;
      wr_sr <= '1;
      pa_sr <= '1;
      ck_sr <= '0;
    end else begin
      rd_sr <= {rd_sr[PRV:0], rd_n_i};
      wr_sr <= {wr_sr[PRV:0], wr_n_i};
      pa_sr <= {pa_sr[PRV:0], periph_n_i};
      ck_sr <= {ck_sr[PRV:0], cpu_clk_i};
    end
  end

  // read: end taken from the strobe, never from the CPU clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_busy    <= 1'b0;
      oe_o       <= 1'b0;
      dly        <= '0;
      rd_pulse_o <= 1'b0;
    end else begin
      rd_pulse_o <= rd_fall;
      if (rd_fall) begin
        rd_busy <= 1'b1;
        dly     <= DW'(OE_DELAY);
        oe_o    <= (OE_DELAY == 0);
      end else if (rd_rise) begin
        rd_busy <= 1'b0;
        oe_o    <= 1'b0;
        dly     <= '0;
      end else if (rd_busy && !oe_o) begin
        if (dly > DW'(1)) dly <= dly - DW'(1);
        else              oe_o <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_busy     <= 1'b0;
      wr_pulse_o  <= 1'b0;
      cycle_end_o <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_periph_o <= 1'b0;
    end else begin
      wr_pulse_o  <= wr_rise;
      cycle_end_o <= rd_rise | wr_rise;
      if (wr_fall) wr_busy <= 1'b1;
      else if (wr_rise) begin
        wr_busy     <= 1'b0;
        wr_addr_o   <= addr_i;
        wr_data_o   <= data_i;
        wr_periph_o <= ~pa_sr[OLD];
      end
    end
  end

  p_oe_in_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_o |-> access_o);
  p_oe_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (OE_DELAY > 0) && rd_pulse_o |-> !oe_o);
  p_end_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end_o |-> !oe_o && !access_o);
  p_wr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_o |=> !wr_pulse_o);
  p_wr_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_o |-> cycle_end_o);
  p_no_oe_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_o |-> !oe_o);

endmodule

// File: tb/bus_access_detect_tb_top.sv
`timescale 1ns/1ps
module bus_access_detect_tb_top;
  localparam int OE_D = 3;

  logic clk = 0, rst_n = 0;
  logic cpu_clk_i = 0, rd_n_i = 1, wr_n_i = 1, periph_n_i = 1;
  logic [7:0] addr_i = 0, data_i = 0;
  logic cpu_clk_sync_o, access_o, rd_pulse_o, wr_pulse_o, cycle_end_o, oe_o, wr_periph_o;
  logic [7:0] wr_addr_o, wr_data_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_access_detect #(.OE_DELAY(OE_D)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_clk_i(cpu_clk_i), .rd_n_i(rd_n_i),
    .wr_n_i(wr_n_i), .periph_n_i(periph_n_i), .addr_i(addr_i), .data_i(data_i),
    .cpu_clk_sync_o(cpu_clk_sync_o), .access_o(access_o), .rd_pulse_o(rd_pulse_o),
    .wr_pulse_o(wr_pulse_o), .cycle_end_o(cycle_end_o), .oe_o(oe_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_periph_o(wr_periph_o));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_startup();
    for (int k = 1; k <= 12; k++) begin
      step();
      chk("R1 access", access_o, 0);
      chk("R1 oe", oe_o, 0);
      chk("R1 rd_pulse", rd_pulse_o, 0);
      chk("R1 wr_pulse", wr_pulse_o, 0);
      chk("R1 cycle_end", cycle_end_o, 0);
      chk("R2 cpu_clk_sync reset", cpu_clk_sync_o, 0);
    end
  endtask

  task automatic t_cpu_clk();
    cpu_clk_i = 1;
    for (int k = 1; k <= 4; k++) begin step(); chk("R2 sync rise", cpu_clk_sync_o, int'(k >= 3)); end
    cpu_clk_i = 0;
    for (int k = 1; k <= 4; k++) begin step(); chk("R2 sync fall", cpu_clk_sync_o, int'(k < 3)); end
  endtask

  task automatic t_read(int hold, bit dma);
    rd_n_i = 0;
    for (int k = 1; k <= 8; k++) begin
      step();
      chk("R3 rd_pulse", rd_pulse_o, int'(k == 3));
      chk("R3 access", access_o, int'(k >= 3));
      chk("R4 oe open", oe_o, int'(k >= 3 + OE_D));
    end
    for (int k = 0; k < hold; k++) begin
      if (dma && (k % 2 == 0)) cpu_clk_i = ~cpu_clk_i;
      step();
      chk(dma ? "R6 oe held" : "R4 oe held", oe_o, 1);
      chk(dma ? "R6 no end" : "R5 no end", cycle_end_o, 0);
    end
    cpu_clk_i = 0;
    rd_n_i = 1;
    for (int k = 1; k <= 5; k++) begin
      step();
      chk("R5 cycle_end", cycle_end_o, int'(k == 3));
      chk("R5 access", access_o, int'(k < 3));
      chk("R5 oe close", oe_o, int'(k < 3));
    end
  endtask

  task automatic t_write(logic [7:0] a, logic [7:0] d, logic pn);
    addr_i = a; data_i = d; periph_n_i = pn; wr_n_i = 0;
    for (int k = 1; k <= 6; k++) begin
      step();
      chk("R8 access", access_o, int'(k >= 3));
      chk("R8 oe", oe_o, 0);
      chk("R7 no early pulse", wr_pulse_o, 0);
    end
    wr_n_i = 1;
    for (int k = 1; k <= 5; k++) begin
      step();
      chk("R7 wr_pulse", wr_pulse_o, int'(k == 3));
      chk("R7 cycle_end", cycle_end_o, int'(k == 3));
      chk("R8 oe", oe_o, 0);
      if (k == 3) begin
        chk("R7 addr", wr_addr_o, a);
        chk("R7 data", wr_data_o, d);
        chk("R7 periph", wr_periph_o, int'(!pn));
      end
    end
    periph_n_i = 1;
  endtask

  initial begin
    #100000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_startup();
    t_cpu_clk();
    t_read(4, 0);
    t_read(24, 1);
    t_write(8'h00, 8'h0F, 0);
    t_write(8'hA5, 8'h3C, 1);
    t_read(1, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule